// File: doc/BRIEF.md
# Committed-Store Writeback Queue

This block keeps in-flight stores in program order inside a circular buffer. Each store takes a slot at allocation and receives its address, data and byte size later, by slot index. When the core commits up to some sequence number, the queue makes the matching stores eligible for writeback. A separate writeback pointer then sends eligible stores, oldest first, to the data cache over a valid/ready channel.

A rejected request is held while the queue waits for a retry pulse from the cache. Stores finish when the cache reports completion by slot index, and completions may arrive in any order. The oldest slot is reclaimed only once it and every older store have finished. A squash removes younger, uncommitted stores from the tail end. The number of free slots is always available at the output.

Top module: `store_queue`

## Requirements
- R1: The queue holds DEPTH stores, using DEPTH+1 slots of storage. freeCount equals DEPTH minus the occupied slots and falls by one the cycle after an accepted allocation. An allocation while freeCount is 0 is ignored.
- R2: Slots are allocated in order, with index wrapping modulo DEPTH+1. Each store keeps the load-queue tag given at allocation and shows it on reqLqTag when it is sent.
- R3: With commitValid, stores are scanned from the oldest. Each store that is not yet eligible and whose sequence number is at most commitSeq is marked eligible. The scan stops at the first store that is not eligible and is younger than commitSeq.
- R4: reqValid is high, with reqIdx/reqAddr/reqData/reqSize of the slot at the writeback pointer, when that slot is eligible, the pointer is not at the tail and the queue is not blocked. This starts in the cycle after the commit edge. An accepted request (reqValid and reqReady) moves the pointer on.
- R5: An eligible store of size 0 raises no request. It is marked finished and the pointer passes it.
- R6: A request refused by the cache (reqValid without reqReady) blocks the queue. While blocked, reqValid is raised only in cycles with cacheRetry, and always for the same slot. Only an accepted retry clears the block and advances the pointer.
- R7: cplValid marks slot cplIdx finished. The oldest slot is released together with every consecutive finished slot after it, so a completion for a younger store frees nothing until the older ones finish.
- R8: With squashValid, stores are removed from the youngest end while their sequence number exceeds squashSeq. Removal stops at the first store that is eligible. The freed slots are handed out again next, and an allocation in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocValid | input | 1 | Allocate a slot at the tail |
| allocSeq | input | SEQW | Sequence number of the new store |
| allocLqTag | input | LQW | Load-queue tail index at allocation |
| wrValid | input | 1 | Write address/data/size into a slot |
| wrIdx | input | IW | Slot written |
| wrAddr | input | AW | Store address |
| wrData | input | DW | Store data |
| wrSize | input | SZW | Store size in bytes, 0 means no access |
| commitValid | input | 1 | Commit up to commitSeq |
| commitSeq | input | SEQW | Youngest committed sequence number |
| squashValid | input | 1 | Squash stores younger than squashSeq |
| squashSeq | input | SEQW | Youngest surviving sequence number |
| reqValid | output | 1 | Cache write request valid |
| reqReady | input | 1 | Cache accepts the request |
| reqIdx | output | IW | Slot of the request |
| reqAddr | output | AW | Request address |
| reqData | output | DW | Request data |
| reqSize | output | SZW | Request size |
| reqLqTag | output | LQW | Load-queue tag of the store |
| cacheRetry | input | 1 | Cache asks for the refused request again |
| cplValid | input | 1 | A store finished in the cache |
| cplIdx | input | IW | Slot that finished |
| freeCount | output | CW | Free slots |

## Verification
The request outputs are combinational from state. They are valid in the cycle after the commit edge, and within that cycle they also follow cacheRetry. freeCount changes right after the edge that takes an allocation, completion or squash. The bench drives each cycle's inputs just after the falling edge and samples 2 ns later, before the rising edge. Each check therefore sees the state left by the previous rising edge together with the current inputs. Expected values in the table are counted edge by edge from this rule.

// File: rtl/sq_pkg.sv
package sq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic allocEn;
    logic wrEn;
  } dpStrobe_t;
endpackage

// File: rtl/sq_datapath.sv
module sq_datapath import sq_pkg::*; #(
  parameter int SLOTS = 5,
  parameter int IW    = 3,
  parameter int SEQW  = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int SZW   = 4,
  parameter int LQW   = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dpStrobe_t                      strobe,
  input  logic [IW-1:0]                  allocIdx,
  input  logic [SEQW-1:0]                allocSeq,
  input  logic [LQW-1:0]                 allocLq,
  input  logic [IW-1:0]                  wrIdx,
  input  logic [AW-1:0]                  wrAddr,
  input  logic [DW-1:0]                  wrData,
  input  logic [SZW-1:0]                 wrSize,
  input  logic [IW-1:0]                  rdIdx,
  output logic [SLOTS-1:0][SEQW-1:0]     seqArr,
  output logic [SLOTS-1:0]               sizeZero,
  output logic [AW-1:0]                  rdAddr,
  output logic [DW-1:0]                  rdData,
  output logic [SZW-1:0]                 rdSize,
  output logic [LQW-1:0]                 rdLq
);
  logic [SLOTS-1:0][AW-1:0]  addrQ;
  logic [SLOTS-1:0][DW-1:0]  dataQ;
  logic [SLOTS-1:0][SZW-1:0] sizeQ;
  logic [SLOTS-1:0][LQW-1:0] lqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      dataQ  <= '0;
      sizeQ  <= '0;
      lqQ    <= '0;
      seqArr <= '0;
    end else begin
      if (strobe.allocEn && int'(allocIdx) < SLOTS) begin
        seqArr[allocIdx] <= allocSeq;
        lqQ[allocIdx]    <= allocLq;
      end
      if (strobe.wrEn && int'(wrIdx) < SLOTS) begin
        addrQ[wrIdx] <= wrAddr;
        dataQ[wrIdx] <= wrData;
        sizeQ[wrIdx] <= wrSize;
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_zero
    assign sizeZero[g] = (sizeQ[g] == '0);
  end

  always_comb begin
    rdAddr = '0;
    rdData = '0;
    rdSize = '0;
    rdLq   = '0;
    if (int'(rdIdx) < SLOTS) begin
      rdAddr = addrQ[rdIdx];
      rdData = dataQ[rdIdx];
      rdSize = sizeQ[rdIdx];
      rdLq   = lqQ[rdIdx];
    end
  end
endmodule

// File: rtl/sq_control.sv
module sq_control import sq_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int SEQW  = 8,
  parameter int PORTS = 1,
  parameter int SLOTS = DEPTH + 1,
  parameter int IW    = $clog2(SLOTS),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       allocValid,
  input  logic                       wrValid,
  input  logic                       commitValid,
  input  logic [SEQW-1:0]            commitSeq,
  input  logic                       squashValid,
  input  logic [SEQW-1:0]            squashSeq,
  input  logic                       cplValid,
  input  logic [IW-1:0]              cplIdx,
  input  logic                       reqReady,
  input  logic                       cacheRetry,
  input  logic [SLOTS-1:0][SEQW-1:0] seqArr,
  input  logic [SLOTS-1:0]           sizeZero,
  output dpStrobe_t                  strobe,
  output logic [IW-1:0]              allocIdx,
  output logic [IW-1:0]              rdIdx,
  output logic                       reqValid,
  output logic [CW-1:0]              freeCount,
  output logic [CW-1:0]              pendingCnt
);
  localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

  function automatic logic [IW-1:0] incIdx(input logic [IW-1:0] x);
    return (x == LAST) ? '0 : x + 1'b1;
  endfunction
  function automatic logic [IW-1:0] decIdx(input logic [IW-1:0] x);
    return (x == '0) ? LAST : x - 1'b1;
  endfunction

  logic [IW-1:0]    headQ, wbQ, tailQ;
  logic [SLOTS-1:0] eligQ, doneQ;
  logic             blockedQ;
  logic [CW-1:0]    pendingQ;

  logic [IW:0]      occ;
  logic             full, allocFire;

  assign occ = (tailQ >= headQ) ? ({1'b0, tailQ} - {1'b0, headQ})
                                : ({1'b0, tailQ} + (IW+1)'(SLOTS) - {1'b0, headQ});
  assign full       = (incIdx(tailQ) == headQ);
  assign allocFire  = allocValid && !full && !squashValid;
  assign freeCount  = CW'(DEPTH) - CW'(occ);
  assign pendingCnt = pendingQ;
  assign allocIdx   = tailQ;
  assign strobe     = '{allocEn: allocFire, wrEn: wrValid};

  // commit marking, oldest first (R3)
  logic [SLOTS-1:0] markVec;
  logic [IW-1:0]    cP;
  logic             cStop;
  always_comb begin
    markVec = '0;
    cP      = headQ;
    cStop   = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (commitValid && !cStop && cP != tailQ) begin
        if (!eligQ[cP]) begin
          if (seqArr[cP] <= commitSeq) markVec[cP] = 1'b1;
          else                         cStop = 1'b1;
        end
        cP = incIdx(cP);
      end
    end
  end

  // writeback pointer walk (R4, R5, R6)
  logic [IW-1:0]    wP;
  logic             wStop, wSent, setBlocked, clrBlocked;
  logic [CW-1:0]    decCnt;
  logic [SLOTS-1:0] zeroVec;
  always_comb begin
    wP         = wbQ;
    wStop      = 1'b0;
    wSent      = 1'b0;
    setBlocked = 1'b0;
    clrBlocked = 1'b0;
    decCnt     = '0;
    zeroVec    = '0;
    reqValid   = 1'b0;
    rdIdx      = wbQ;
    if (blockedQ) begin
      if (cacheRetry) begin
        reqValid = 1'b1;
        if (reqReady) begin
          wP         = incIdx(wbQ);
          decCnt     = CW'(1);
          clrBlocked = 1'b1;
        end
      end
    end else begin
      for (int k = 0; k < PORTS; k++) begin
        if (!wStop && wP != tailQ && eligQ[wP]) begin
          if (sizeZero[wP]) begin
            zeroVec[wP] = 1'b1;
            wP          = incIdx(wP);
            decCnt      = decCnt + CW'(1);
          end else if (!wSent) begin
            wSent    = 1'b1;
            reqValid = 1'b1;
            rdIdx    = wP;
            if (reqReady) begin
              wP     = incIdx(wP);
              decCnt = decCnt + CW'(1);
            end else begin
              setBlocked = 1'b1;
              wStop      = 1'b1;
            end
          end else begin
            wStop = 1'b1;
          end
        end else begin
          wStop = 1'b1;
        end
      end
    end
  end

  // completion and head reclaim (R7)
  logic [SLOTS-1:0] doneAll, freeVec;
  logic [IW-1:0]    hP;
  logic             hStop;
  always_comb begin
    doneAll = doneQ | zeroVec;
    if (cplValid && int'(cplIdx) < SLOTS) doneAll[cplIdx] = 1'b1;
    freeVec = '0;
    hP      = headQ;
    hStop   = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!hStop && hP != tailQ && doneAll[hP]) begin
        freeVec[hP] = 1'b1;
        hP          = incIdx(hP);
      end else begin
        hStop = 1'b1;
      end
    end
  end

  // squash from the tail (R8)
  logic [SLOTS-1:0] eligAfter, killVec;
  logic [IW-1:0]    sT, sQ;
  logic             sStop;
  always_comb begin
    eligAfter = eligQ | markVec;
    killVec   = '0;
    sT        = tailQ;
    sQ        = tailQ;
    sStop     = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (squashValid && !sStop && sT != headQ) begin
        sQ = decIdx(sT);
        if (seqArr[sQ] > squashSeq && !eligAfter[sQ]) begin
          killVec[sQ] = 1'b1;
          sT          = sQ;
        end else begin
          sStop = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ    <= '0;
      wbQ      <= '0;
      tailQ    <= '0;
      eligQ    <= '0;
      doneQ    <= '0;
      blockedQ <= 1'b0;
      pendingQ <= '0;
    end else begin
      headQ    <= hP;
      wbQ      <= wP;
      if (squashValid)    tailQ <= sT;
      else if (allocFire) tailQ <= incIdx(tailQ);
      eligQ    <= eligAfter & ~freeVec & ~killVec;
      doneQ    <= doneAll & ~freeVec & ~killVec;
      if (setBlocked)      blockedQ <= 1'b1;
      else if (clrBlocked) blockedQ <= 1'b0;
      pendingQ <= pendingQ + CW'($countones(markVec)) - decCnt;
    end
  end
endmodule

// File: rtl/store_queue.sv
module store_queue import sq_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int SEQW  = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int SZW   = 4,
  parameter int LQW   = 4,
  parameter int PORTS = 1,
  localparam int SLOTS = DEPTH + 1,
  localparam int IW    = $clog2(SLOTS),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            allocValid,
  input  logic [SEQW-1:0] allocSeq,
  input  logic [LQW-1:0]  allocLqTag,
  input  logic            wrValid,
  input  logic [IW-1:0]   wrIdx,
  input  logic [AW-1:0]   wrAddr,
  input  logic [DW-1:0]   wrData,
  input  logic [SZW-1:0]  wrSize,
  input  logic            commitValid,
  input  logic [SEQW-1:0] commitSeq,
  input  logic            squashValid,
  input  logic [SEQW-1:0] squashSeq,
  output logic            reqValid,
  input  logic            reqReady,
  output logic [IW-1:0]   reqIdx,
  output logic [AW-1:0]   reqAddr,
  output logic [DW-1:0]   reqData,
  output logic [SZW-1:0]  reqSize,
  output logic [LQW-1:0]  reqLqTag,
  input  logic            cacheRetry,
  input  logic            cplValid,
  input  logic [IW-1:0]   cplIdx,
  output logic [CW-1:0]   freeCount
);
  dpStrobe_t                  strobe;
  logic [IW-1:0]              allocIdx;
  logic [SLOTS-1:0][SEQW-1:0] seqArr;
  logic [SLOTS-1:0]           sizeZero;
  logic [CW-1:0]              pendingCnt;

  sq_control #(
    .DEPTH(DEPTH), .SEQW(SEQW), .PORTS(PORTS),
    .SLOTS(SLOTS), .IW(IW), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .wrValid(wrValid),
    .commitValid(commitValid), .commitSeq(commitSeq),
    .squashValid(squashValid), .squashSeq(squashSeq),
    .cplValid(cplValid), .cplIdx(cplIdx),
    .reqReady(reqReady), .cacheRetry(cacheRetry),
    .seqArr(seqArr), .sizeZero(sizeZero),
    .strobe(strobe), .allocIdx(allocIdx), .rdIdx(reqIdx),
    .reqValid(reqValid), .freeCount(freeCount), .pendingCnt(pendingCnt)
  );

  sq_datapath #(
    .SLOTS(SLOTS), .IW(IW), .SEQW(SEQW), .AW(AW),
    .DW(DW), .SZW(SZW), .LQW(LQW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .allocIdx(allocIdx), .allocSeq(allocSeq), .allocLq(allocLqTag),
    .wrIdx(wrIdx), .wrAddr(wrAddr), .wrData(wrData), .wrSize(wrSize),
    .rdIdx(reqIdx), .seqArr(seqArr), .sizeZero(sizeZero),
    .rdAddr(reqAddr), .rdData(reqData), .rdSize(reqSize), .rdLq(reqLqTag)
  );
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int DEPTH = 4,
  parameter int IW    = 3,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          allocValid,
  input logic          squashValid,
  input logic          cplValid,
  input logic          reqValid,
  input logic          reqReady,
  input logic          cacheRetry,
  input logic [IW-1:0] reqIdx,
  input logic [CW-1:0] freeCount,
  input logic [CW-1:0] pendingCnt
);
  a_r1_free_bound: assert property (@(posedge clk) disable iff (!rstN)
    freeCount <= CW'(DEPTH));

  a_r1_alloc_takes_slot: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && freeCount != '0 && !squashValid && !cplValid && pendingCnt == '0)
    |=> freeCount == CW'($past(freeCount) - 1'b1));

  a_r4_issue_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    (pendingCnt == '0) |-> !reqValid);

  a_r6_blocked_waits_retry: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (!reqValid || cacheRetry));

  a_r6_resend_same_slot: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (!reqValid || reqIdx == $past(reqIdx)));
endmodule

bind store_queue sq_checker #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_sqChecker (
  .clk(clk), .rstN(rstN), .allocValid(allocValid), .squashValid(squashValid),
  .cplValid(cplValid), .reqValid(reqValid), .reqReady(reqReady),
  .cacheRetry(cacheRetry), .reqIdx(reqIdx), .freeCount(freeCount),
  .pendingCnt(pendingCnt)
);

// File: tb/test_store_queue.sv
module test_store_queue;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        allocValid, wrValid, commitValid, squashValid, cplValid;
  logic        reqReady, cacheRetry;
  logic [7:0]  allocSeq, commitSeq, squashSeq;
  logic [3:0]  allocLqTag;
  logic [2:0]  wrIdx, cplIdx;
  logic [15:0] wrAddr;
  logic [31:0] wrData;
  logic [3:0]  wrSize;
  logic        reqValid;
  logic [2:0]  reqIdx;
  logic [15:0] reqAddr;
  logic [31:0] reqData;
  logic [3:0]  reqSize, reqLqTag;
  logic [2:0]  freeCount;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  store_queue i_store_queue (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocSeq(allocSeq), .allocLqTag(allocLqTag),
    .wrValid(wrValid), .wrIdx(wrIdx), .wrAddr(wrAddr), .wrData(wrData), .wrSize(wrSize),
    .commitValid(commitValid), .commitSeq(commitSeq),
    .squashValid(squashValid), .squashSeq(squashSeq),
    .reqValid(reqValid), .reqReady(reqReady), .reqIdx(reqIdx),
    .reqAddr(reqAddr), .reqData(reqData), .reqSize(reqSize), .reqLqTag(reqLqTag),
    .cacheRetry(cacheRetry), .cplValid(cplValid), .cplIdx(cplIdx),
    .freeCount(freeCount)
  );

  typedef struct packed {
    logic al, wr, cm, sq, cp;
    logic [7:0]  seq;
    logic [3:0]  lq;
    logic [2:0]  idx;
    logic [15:0] addr;
    logic [3:0]  size;
    logic        rdy, rty;
    logic [2:0]  eFree;
    logic        eRv;
    logic [2:0]  eIdx;
    logic [15:0] eAddr;
    logic [3:0]  eLq;
    logic [3:0]  eSize;
    logic [3:0]  req;
  } vec_t;

  // al wr cm sq cp | seq lq idx addr size | rdy rty | eFree eRv eIdx eAddr eLq eSize | req
  localparam vec_t VECS [18] = '{
    '{1,0,0,0,0, 10,3,0,'h0000,0, 1,0, 4,0,0,'h0000,0,0, 1}, // R1 empty
    '{1,1,0,0,0, 11,5,0,'h0100,4, 1,0, 3,0,0,'h0000,0,0, 1}, // R1
    '{1,1,0,0,0, 12,7,1,'h0000,0, 1,0, 2,0,0,'h0000,0,0, 1}, // R1 slot1 size 0
    '{1,1,0,0,0, 13,9,2,'h0300,8, 1,0, 1,0,0,'h0000,0,0, 1}, // R1
    '{1,0,0,0,0, 14,0,0,'h0000,0, 1,0, 0,0,0,'h0000,0,0, 1}, // R1 full, alloc ignored
    '{0,0,1,0,0, 11,0,0,'h0000,0, 1,0, 0,0,0,'h0000,0,0, 1}, // R1 still full; commit 11
    '{0,0,0,0,0,  0,0,0,'h0000,0, 1,0, 0,1,0,'h0100,3,4, 4}, // R4 R2 slot0 sent
    '{0,0,0,0,0,  0,0,0,'h0000,0, 1,0, 0,0,0,'h0000,0,0, 5}, // R5 zero-size, no request
    '{0,0,0,0,1,  0,0,0,'h0000,0, 1,0, 0,0,0,'h0000,0,0, 3}, // R3 slot2 not marked
    '{0,0,0,1,0, 12,0,0,'h0000,0, 1,0, 2,0,0,'h0000,0,0, 7}, // R7 head past 0,1
    '{0,0,1,0,0, 12,0,0,'h0000,0, 1,0, 3,0,0,'h0000,0,0, 8}, // R8 seq13 removed
    '{0,0,0,0,0,  0,0,0,'h0000,0, 0,0, 3,1,2,'h0300,7,8, 4}, // R4 refused
    '{0,0,0,0,0,  0,0,0,'h0000,0, 1,0, 3,0,0,'h0000,0,0, 6}, // R6 blocked, no retry
    '{0,0,0,0,0,  0,0,0,'h0000,0, 0,1, 3,1,2,'h0300,7,8, 6}, // R6 retry refused
    '{0,0,0,0,0,  0,0,0,'h0000,0, 1,1, 3,1,2,'h0300,7,8, 6}, // R6 retry accepted
    '{0,0,0,0,0,  0,0,0,'h0000,0, 1,0, 3,0,0,'h0000,0,0, 6}, // R6 nothing left
    '{0,0,0,0,1,  0,0,2,'h0000,0, 1,0, 3,0,0,'h0000,0,0, 7}, // R7 complete slot2
    '{0,0,0,0,0,  0,0,0,'h0000,0, 1,0, 4,0,0,'h0000,0,0, 7}  // R7 all free
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearIns();
    allocValid = 0; wrValid = 0; commitValid = 0; squashValid = 0; cplValid = 0;
    cacheRetry = 0; reqReady = 1;
    allocSeq = 0; allocLqTag = 0; commitSeq = 0; squashSeq = 0;
    wrIdx = 0; wrAddr = 0; wrData = 0; wrSize = 0; cplIdx = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
    clearIns();
  endtask

  task automatic doAlloc(input logic [7:0] s, input logic [3:0] lq);
    allocValid = 1; allocSeq = s; allocLqTag = lq;
  endtask

  task automatic doWrite(input logic [2:0] i, input logic [15:0] a, input logic [3:0] sz);
    wrValid = 1; wrIdx = i; wrAddr = a; wrData = {16'hDA7A, a}; wrSize = sz;
  endtask

  task automatic expectReq(input string req, input logic [2:0] i, input logic [15:0] a);
    #2;
    chk(req, "reqValid", 32'(reqValid), 1);
    chk(req, "reqIdx", 32'(reqIdx), 32'(i));
    chk(req, "reqAddr", 32'(reqAddr), 32'(a));
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clearIns();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #2;
    chk("R1", "reset freeCount", 32'(freeCount), 4);
    chk("R4", "reset reqValid", 32'(reqValid), 0);

    foreach (VECS[n]) begin
      @(negedge clk);
      clearIns();
      allocValid  = VECS[n].al;
      allocSeq    = VECS[n].seq;
      allocLqTag  = VECS[n].lq;
      commitValid = VECS[n].cm;
      commitSeq   = VECS[n].seq;
      squashValid = VECS[n].sq;
      squashSeq   = VECS[n].seq;
      cplValid    = VECS[n].cp;
      cplIdx      = VECS[n].idx;
      reqReady    = VECS[n].rdy;
      cacheRetry  = VECS[n].rty;
      if (VECS[n].wr) doWrite(VECS[n].idx, VECS[n].addr, VECS[n].size);
      #2;
      chk($sformatf("R%0d", VECS[n].req), $sformatf("v%0d freeCount", n), 32'(freeCount), 32'(VECS[n].eFree));
      chk($sformatf("R%0d", VECS[n].req), $sformatf("v%0d reqValid", n), 32'(reqValid), 32'(VECS[n].eRv));
      if (VECS[n].eRv) begin
        chk("R4", $sformatf("v%0d reqIdx", n), 32'(reqIdx), 32'(VECS[n].eIdx));
        chk("R4", $sformatf("v%0d reqAddr", n), 32'(reqAddr), 32'(VECS[n].eAddr));
        chk("R4", $sformatf("v%0d reqData", n), reqData, {16'hDA7A, VECS[n].eAddr});
        chk("R4", $sformatf("v%0d reqSize", n), 32'(reqSize), 32'(VECS[n].eSize));
        chk("R2", $sformatf("v%0d reqLqTag", n), 32'(reqLqTag), 32'(VECS[n].eLq));
      end
    end

    // R7: out-of-order completion (slots 3 and 4, tail wraps to 0)
    cyc(); doAlloc(20, 1);
    cyc(); doAlloc(21, 2); doWrite(3, 16'h0400, 4);
    cyc(); doWrite(4, 16'h0500, 4);
    cyc(); commitValid = 1; commitSeq = 21;
    cyc(); expectReq("R2", 3, 16'h0400);
    chk("R2", "lq tag slot3", 32'(reqLqTag), 1);
    cyc(); expectReq("R4", 4, 16'h0500);
    cyc(); cplValid = 1; cplIdx = 4;
    cyc(); #2; chk("R7", "younger done frees nothing", 32'(freeCount), 2);
    cplValid = 1; cplIdx = 3;
    cyc(); #2; chk("R7", "older done frees both", 32'(freeCount), 4);

    // R8: squash stops at an eligible store; freed slot reused
    doAlloc(30, 0); doWrite(0, 16'h0600, 4);
    cyc(); doAlloc(31, 0);
    cyc(); doAlloc(32, 0);
    cyc(); commitValid = 1; commitSeq = 30;
    cyc(); squashValid = 1; squashSeq = 0;
    #2; chk("R8", "slot0 sent during squash", 32'(reqValid), 1);
    cyc(); #2;
    chk("R8", "free after squash", 32'(freeCount), 3);
    chk("R8", "no request after squash", 32'(reqValid), 0);
    cplValid = 1; cplIdx = 0;
    cyc(); #2; chk("R8", "free after completion", 32'(freeCount), 4);
    doAlloc(40, 6); doWrite(1, 16'h0777, 2);
    cyc(); commitValid = 1; commitSeq = 40;
    cyc(); expectReq("R8", 1, 16'h0777);
    chk("R2", "lq tag reused slot", 32'(reqLqTag), 6);
    cyc(); cplValid = 1; cplIdx = 1;
    cyc(); #2; chk("R7", "final free", 32'(freeCount), 4);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule